// File: doc/BRIEF.md
# DDR3 Command-Rate Pacer

This block decides how often a two-channel DDR3 controller may put a command on the bus. It reads a presence bit for every DIMM slot of both channels. A channel with two modules loaded needs a command slot only every second clock (2N). A channel with one module can take a command every clock (1N). One rate is shared by both channels: if either channel needs 2N, both channels run at 2N. The block also tells each channel's power-down logic which exit flavour to use, and it raises an error for a population that cannot work.

The population is sampled only on a one-cycle `cfg_load` strobe and held until the next strobe. After each strobe, a shared phase toggle starts again at its even phase. Each channel has a request/ready pair. A grant is given in a cycle where the request and ready are both high. While an error is latched, ready stays low and nothing is granted.

Top module: `cmdrate_pace`

## Requirements
- R1: After synchronous reset, `rate_2n`=0, `pd_fast_exit`=0 and `cfg_err`=1, so both `cmd_ready` bits are 0 until a valid configuration is loaded.
- R2: A channel whose slots hold two DIMMs requires 2N. `rate_2n` is 1 if either channel requires 2N and 0 otherwise.
- R3: In 1N with no error, `cmd_ready` is 1 on every clock.
- R4: In 2N with no error, `cmd_ready` is 1 in the first cycle after the `cfg_load` edge and on every second cycle after that. It is 0 in the cycles in between.
- R5: In 2N with no error, a request that sees ready low is served on the very next clock, so it waits exactly one cycle.
- R6: `pd_fast_exit[c]` is 1 (keep the DLL on) when channel c holds two DIMMs. It is 0 (slow exit) when the channel holds one or none.
- R7: Slot bit `slot_present[2c]` is the far slot of channel c and `slot_present[2c+1]` is its near slot. `cfg_err` is 1 when a channel has its near slot filled and its far slot empty, or when no slot at all is filled.
- R8: While `cfg_err` is 1, `cmd_ready` and `cmd_grant` are all 0.
- R9: `rate_2n`, `pd_fast_exit` and `cfg_err` change only on the clock edge where `cfg_load` is 1. A change of `slot_present` without the strobe has no effect on them.
- R10: `cmd_grant[c]` equals `cmd_req[c] & cmd_ready[c]`, so there is never a grant without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Strobe that latches the slot population |
| slot_present | input | 4 | Presence bits; bit 2c is the far slot of channel c, bit 2c+1 is its near slot |
| cmd_req | input | 2 | Per-channel command request |
| cmd_ready | output | 2 | Per-channel command slot open |
| cmd_grant | output | 2 | Per-channel command issued this cycle |
| rate_2n | output | 1 | Shared command rate, 1 = 2N |
| pd_fast_exit | output | 2 | Per-channel power-down exit, 1 = fast |
| cfg_err | output | 1 | Illegal population latched |

## Verification
All sixteen slot populations are loaded in turn. Together they separate the three cases that decide the outcome: a channel with two DIMMs, a channel with one DIMM, and a channel with a missing far slot, in every pairing across the two channels. The all-empty population is one of the sixteen. After each load, the request pattern shifts from cycle to cycle, so a grant that ignores the request, the ready bit or the phase shows up in a different place for each population. Each load is followed by a change of the slot bits without a strobe, which shows whether the latched outputs follow the live inputs.

// File: rtl/cmdrate_pkg.sv
package cmdrate_pkg;

    typedef enum logic {
        CMD_1N = 1'b0,
        CMD_2N = 1'b1
    } cmd_rate_e;

    typedef struct packed {
        logic populated;
        logic dual;
        logic bad;
    } chan_need_t;

    function automatic chan_need_t classify(input logic far_slot, input int unsigned cnt);
        chan_need_t n;
        n.populated = (cnt != 0);
        n.dual      = (cnt >= 2);
        n.bad       = (cnt != 0) && !far_slot;
        return n;
    endfunction

endpackage

// File: rtl/cmdrate_chan_decode.sv
module cmdrate_chan_decode
    import cmdrate_pkg::*;
#(
    parameter int SLOTS = 2
) (
    input  logic [SLOTS-1:0] present,
    output chan_need_t       need
);
    localparam int CW = $clog2(SLOTS + 1);

    logic [CW-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int s = 0; s < SLOTS; s++) begin
            cnt = cnt + CW'(present[s]);
        end
    end

    assign need = classify(present[0], 32'(cnt));

endmodule

// File: rtl/cmdrate_cfg_reg.sv
module cmdrate_cfg_reg
    import cmdrate_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  chan_need_t [NUM_CH-1:0]  needs,
    output cmd_rate_e                rate,
    output logic                     err,
    output logic [NUM_CH-1:0]        fast_exit
);
    logic any_dual, any_bad, any_pop;

    always_comb begin
        any_dual = 1'b0;
        any_bad  = 1'b0;
        any_pop  = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            any_dual = any_dual | needs[c].dual;
            any_bad  = any_bad  | needs[c].bad;
            any_pop  = any_pop  | needs[c].populated;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate <= CMD_1N;
            err  <= 1'b1;
        end else if (load) begin
            rate <= any_dual ? CMD_2N : CMD_1N;
            err  <= any_bad | ~any_pop;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_exit
        always_ff @(posedge clk) begin
            if (rst) begin
                fast_exit[c] <= 1'b0;
            end else if (load) begin
                fast_exit[c] <= needs[c].dual;
            end
        end
    end

    // R9: latched configuration holds without a strobe
    a_r9_hold_cfg: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> ($stable(rate) && $stable(err) && $stable(fast_exit)));

    // R7: an empty population always latches an error
    a_r7_empty_err: assert property (@(posedge clk) disable iff (rst)
        (load && !any_pop) |=> err);

    // R1: leaving reset leaves the error set
    a_r1_reset_err: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> err);

endmodule

// File: rtl/cmdrate_slot_gate.sv
module cmdrate_slot_gate
    import cmdrate_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  cmd_rate_e         rate,
    input  logic              err,
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] ready,
    output logic [NUM_CH-1:0] grant
);
    logic phase_q;
    logic slot_open;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign slot_open = ~err & ((rate == CMD_1N) | ~phase_q);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ready[c] = slot_open;
        assign grant[c] = req[c] & slot_open;
    end

    // R8: an error blocks every grant
    a_r8_err_blocks: assert property (@(posedge clk) disable iff (rst)
        err |-> (grant == '0 && ready == '0));

    // R10: no grant without a request
    a_r10_req_needed: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    // R4: in 2N an open slot is followed by a closed one
    a_r4_alternate: assert property (@(posedge clk) disable iff (rst)
        (rate == CMD_2N && !err && ready[0] && !load) |=> !ready[0]);

    // R5: a stalled request waits exactly one clock
    a_r5_stall_one: assert property (@(posedge clk) disable iff (rst)
        (rate == CMD_2N && !err && !ready[0] && !load) |=> ready[0]);

    // R3: 1N opens every cycle
    a_r3_every_clock: assert property (@(posedge clk) disable iff (rst)
        (rate == CMD_1N && !err) |-> (&ready));

endmodule

// File: rtl/cmdrate_pace.sv
module cmdrate_pace
    import cmdrate_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int SLOTS  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_load,
    input  logic [NUM_CH*SLOTS-1:0]   slot_present,
    input  logic [NUM_CH-1:0]         cmd_req,
    output logic [NUM_CH-1:0]         cmd_ready,
    output logic [NUM_CH-1:0]         cmd_grant,
    output logic                      rate_2n,
    output logic [NUM_CH-1:0]         pd_fast_exit,
    output logic                      cfg_err
);
    chan_need_t [NUM_CH-1:0] needs;
    cmd_rate_e               rate;
    logic                    err;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        cmdrate_chan_decode #(.SLOTS(SLOTS)) u_dec (
            .present (slot_present[c*SLOTS +: SLOTS]),
            .need    (needs[c])
        );
    end

    cmdrate_cfg_reg #(.NUM_CH(NUM_CH)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (cfg_load),
        .needs     (needs),
        .rate      (rate),
        .err       (err),
        .fast_exit (pd_fast_exit)
    );

    cmdrate_slot_gate #(.NUM_CH(NUM_CH)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .load  (cfg_load),
        .rate  (rate),
        .err   (err),
        .req   (cmd_req),
        .ready (cmd_ready),
        .grant (cmd_grant)
    );

    assign rate_2n = (rate == CMD_2N);
    assign cfg_err = err;

endmodule

// File: tb/sim_cmdrate_pace.sv
module sim_cmdrate_pace;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0;
    logic [3:0] slot_present = '0;
    logic [1:0] cmd_req = '0;
    logic [1:0] cmd_ready, cmd_grant, pd_fast_exit;
    logic       rate_2n, cfg_err;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cmdrate_pace u0 (
        .clk          (clk),
        .rst          (rst),
        .cfg_load     (cfg_load),
        .slot_present (slot_present),
        .cmd_req      (cmd_req),
        .cmd_ready    (cmd_ready),
        .cmd_grant    (cmd_grant),
        .rate_2n      (rate_2n),
        .pd_fast_exit (pd_fast_exit),
        .cfg_err      (cfg_err)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic       e_err, e_mode, e_rdy;
        logic [1:0] e_fast;
        cmd_req = 2'b11;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 rate", 8'(rate_2n), 8'd0);
        chk("R1 err", 8'(cfg_err), 8'd1);
        chk("R1 fast", 8'(pd_fast_exit), 8'd0);
        chk("R1 ready", 8'(cmd_ready), 8'd0);
        chk("R8 grant in reset err", 8'(cmd_grant), 8'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R8 ready before load", 8'(cmd_ready), 8'd0);

        for (int p = 0; p < 16; p++) begin
            e_err  = (p == 0);
            e_mode = 1'b0;
            for (int c = 0; c < 2; c++) begin
                logic far_s, near_s;
                far_s  = p[2*c];
                near_s = p[2*c+1];
                if (near_s && !far_s) e_err = 1'b1;
                e_fast[c] = far_s & near_s;
                if (far_s & near_s) e_mode = 1'b1;
            end
            @(negedge clk);
            slot_present = 4'(p);
            cfg_load = 1'b1;
            @(negedge clk);
            cfg_load = 1'b0;
            for (int k = 0; k < 6; k++) begin
                logic [1:0] rq;
                rq = 2'((k + p) & 3);
                cmd_req = rq;
                #1;
                if (k == 0) begin
                    chk("R2 rate", 8'(rate_2n), 8'(e_mode));
                    chk("R7 err", 8'(cfg_err), 8'(e_err));
                    chk("R6 fast exit", 8'(pd_fast_exit), 8'(e_fast));
                end
                e_rdy = !e_err && (!e_mode || (k % 2 == 0));
                if (e_err)       chk("R8 ready", 8'(cmd_ready), 8'd0);
                else if (e_mode) chk("R4 ready 2N", 8'(cmd_ready), 8'({e_rdy, e_rdy}));
                else             chk("R3 ready 1N", 8'(cmd_ready), 8'({e_rdy, e_rdy}));
                chk("R10 grant", 8'(cmd_grant), 8'(rq & {e_rdy, e_rdy}));
                if (!e_err && e_mode && (k % 2 == 1))
                    chk("R5 stall lasts one", 8'(cmd_ready), 8'd0);
                if (!e_err && e_mode && k > 0 && (k % 2 == 0))
                    chk("R5 served next", 8'(cmd_ready), 8'd3);
                @(negedge clk);
            end
            slot_present = ~4'(p);
            @(negedge clk);
            #1;
            chk("R9 rate held", 8'(rate_2n), 8'(e_mode));
            chk("R9 err held", 8'(cfg_err), 8'(e_err));
            chk("R9 fast held", 8'(pd_fast_exit), 8'(e_fast));
        end
        finish_run();
    end
endmodule